// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is a small datapath in which four general registers exchange words over one shared bus. A select code picks which register drives the bus. Per-register load strobes pick which registers take the bus value at the next rising clock edge. All bus loads are qualified by a single condition bit, so a transfer written as "if condition, destination takes source" is one cycle of control.

A synchronous word memory sits beside the registers. It is addressed by an address register and exchanges data through a data register. Both of these registers are loaded from the same bus. An initialisation path lets an external word take over the bus, which is how the registers are given their first values.

The bus drivers behave like tri-state buffers controlled by a 2-to-4 decoder with an enable. They are modelled as a one-hot driver-enable vector feeding an AND-OR network, so an undriven bus reads as zero.

Top module: `bus_xfer_system`

## Requirements
- R1: While `rst` is high at a rising edge, all four registers, the address register and the data register become zero at that edge.
- R2: The bus carries `init_data` when `init_en` is 1. Otherwise, if `bus_en` is 1, it carries register `bus_sel`, where code 0 is register 0 at `regs_q[7:0]` and code 3 is register 3 at `regs_q[31:24]`. Exactly one driver enable is active in that case, and none is active when the bus comes from `init_data` or is idle.
- R3: On an edge where `cond` is 1 and `load_en[i]` is 1, register i takes the bus value. When several bits of `load_en` are set, every selected register takes the same value.
- R4: On an edge where `cond` is 0, no register, address register or data register changes through its bus load, whatever the load strobes are.
- R5: The source of a transfer keeps its contents. This also holds when a register is both the source and the destination.
- R6: On an edge where `cond` and `ar_ld` are 1, the address register takes the low `AW` bits of the bus; otherwise it holds. On an edge where `cond` and `dr_ld` are 1 and `mem_rd` is 0, the data register takes the bus value.
- R7: On an edge where `mem_wr` is 1, the word at the address held in the address register is replaced by the data register's value.
- R8: On an edge where `mem_rd` is 1, the data register takes the word at the address register's address, so it is visible one clock after the strobe. `mem_rd` takes priority over `dr_ld`.
- R9: When `mem_rd` and `mem_wr` are both 1 on the same edge, the data register receives the word as it was before that edge, and the memory receives the data register's previous value.
- R10: When both `init_en` and `bus_en` are 0, the bus reads as all zeros, and a register loaded in that cycle becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| init_en | input | 1 | External word takes the bus |
| init_data | input | DW | External initialisation word |
| bus_en | input | 1 | Enable of the driver decoder |
| bus_sel | input | SELW | Index of the register driving the bus |
| cond | input | 1 | Condition qualifying all bus loads |
| load_en | input | NREG | Per-register load strobes |
| ar_ld | input | 1 | Load the address register from the bus |
| dr_ld | input | 1 | Load the data register from the bus |
| mem_rd | input | 1 | Read the addressed word into the data register |
| mem_wr | input | 1 | Write the data register to the addressed word |
| bus_q | output | DW | Current bus value |
| regs_q | output | NREG*DW | Register contents, register i at bits i*DW upward |
| ar_q | output | AW | Address register |
| dr_q | output | DW | Data register |

## Verification
The hardest case to reach is a read and a write hitting the same address on the same edge. That needs a known word already in memory, the address register pointing at it, and a different value in the data register, all at once. The stimulus first fills every memory word through the initialisation path with address-derived values. It then loads the address and data registers, fires both strobes together, and reads again to observe both halves of the exchange. A reference model that tracks every register, memory word and the bus each cycle then follows a long stretch of random control patterns.

// File: rtl/bus_xfer_pkg.sv
package bus_xfer_pkg;
  // a driver is enabled when the decoder is on and its index is selected
  function automatic logic src_hit(input int sel, input int idx, input logic en);
    return en && (sel == idx);
  endfunction

  // the bus either carries the external word or the driven register word
  function automatic logic take_external(input logic init_en);
    return init_en;
  endfunction
endpackage

// File: rtl/bus_src_decoder.sv
module bus_src_decoder #(
  parameter int NSRC = 4,
  parameter int SELW = $clog2(NSRC)
) (
  input  logic [SELW-1:0] sel,
  input  logic            en,
  output logic [NSRC-1:0] drv_oh
);
  import bus_xfer_pkg::*;
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      drv_oh[i] = src_hit(int'(sel), i, en);
    end
  end
endmodule

// File: rtl/bus_mux.sv
module bus_mux #(
  parameter int NSRC = 4,
  parameter int DW   = 8
) (
  input  logic [NSRC*DW-1:0] srcs,
  input  logic [NSRC-1:0]    drv_oh,
  output logic [DW-1:0]      bus
);
  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (drv_oh[i]) bus = bus | srcs[i*DW +: DW];
    end
  end
endmodule

// File: rtl/xfer_reg.sv
module xfer_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/xfer_mem.sv
module xfer_mem #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[addr] <= wdata;
  end

  assign rdata = words[addr];
endmodule

// File: rtl/bus_xfer_system.sv
module bus_xfer_system #(
  parameter int DW   = 8,
  parameter int AW   = 4,
  parameter int NREG = 4,
  parameter int SELW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               init_en,
  input  logic [DW-1:0]      init_data,
  input  logic               bus_en,
  input  logic [SELW-1:0]    bus_sel,
  input  logic               cond,
  input  logic [NREG-1:0]    load_en,
  input  logic               ar_ld,
  input  logic               dr_ld,
  input  logic               mem_rd,
  input  logic               mem_wr,
  output logic [DW-1:0]      bus_q,
  output logic [NREG*DW-1:0] regs_q,
  output logic [AW-1:0]      ar_q,
  output logic [DW-1:0]      dr_q
);
  import bus_xfer_pkg::*;

  // named internal events for the checker
  logic [NREG-1:0] drv_oh;
  logic [NREG-1:0] ld_fire;
  logic            dec_en;
  logic            ar_fire;
  logic            dr_bus_fire;
  logic [DW-1:0]   mux_bus;
  logic [DW-1:0]   mem_word;
  logic [DW-1:0]   dr_next;

  assign dec_en = bus_en && !take_external(init_en);

  bus_src_decoder #(.NSRC(NREG), .SELW(SELW)) dec_i (
    .sel    (bus_sel),
    .en     (dec_en),
    .drv_oh (drv_oh)
  );

  bus_mux #(.NSRC(NREG), .DW(DW)) mux_i (
    .srcs   (regs_q),
    .drv_oh (drv_oh),
    .bus    (mux_bus)
  );

  assign bus_q = take_external(init_en) ? init_data : mux_bus;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign ld_fire[g] = cond && load_en[g];
    xfer_reg #(.W(DW)) r_i (
      .clk (clk),
      .rst (rst),
      .ld  (ld_fire[g]),
      .d   (bus_q),
      .q   (regs_q[g*DW +: DW])
    );
  end

  assign ar_fire = cond && ar_ld;
  xfer_reg #(.W(AW)) ar_i (
    .clk (clk),
    .rst (rst),
    .ld  (ar_fire),
    .d   (bus_q[AW-1:0]),
    .q   (ar_q)
  );

  assign dr_bus_fire = cond && dr_ld;
  assign dr_next     = mem_rd ? mem_word : bus_q;
  xfer_reg #(.W(DW)) dr_i (
    .clk (clk),
    .rst (rst),
    .ld  (mem_rd || dr_bus_fire),
    .d   (dr_next),
    .q   (dr_q)
  );

  xfer_mem #(.DW(DW), .AW(AW)) mem_i (
    .clk   (clk),
    .we    (mem_wr),
    .addr  (ar_q),
    .wdata (dr_q),
    .rdata (mem_word)
  );
endmodule

module bus_xfer_chk #(
  parameter int DW   = 8,
  parameter int AW   = 4,
  parameter int NREG = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               init_en,
  input logic               bus_en,
  input logic               cond,
  input logic [NREG-1:0]    load_en,
  input logic               ar_ld,
  input logic               dr_ld,
  input logic               mem_rd,
  input logic [NREG-1:0]    drv_oh,
  input logic [DW-1:0]      bus_q,
  input logic [NREG*DW-1:0] regs_q,
  input logic [AW-1:0]      ar_q,
  input logic [DW-1:0]      dr_q
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (regs_q == '0 && ar_q == '0 && dr_q == '0));

  assert_one_driver_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !init_en) |-> $countones(drv_oh) == 1);

  assert_no_driver_R2: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !init_en) |-> drv_oh == '0);

  assert_idle_bus_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (!bus_en && !init_en) |-> bus_q == '0);

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
      (cond && load_en[g]) |=> regs_q[g*DW +: DW] == $past(bus_q));
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !(cond && load_en[g]) |=> $stable(regs_q[g*DW +: DW]));
  end

  assert_ar_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(cond && ar_ld) |=> $stable(ar_q));

  assert_dr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd || (cond && dr_ld)) |=> $stable(dr_q));
endmodule

bind bus_xfer_system bus_xfer_chk #(.DW(DW), .AW(AW), .NREG(NREG)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .init_en (init_en),
  .bus_en  (bus_en),
  .cond    (cond),
  .load_en (load_en),
  .ar_ld   (ar_ld),
  .dr_ld   (dr_ld),
  .mem_rd  (mem_rd),
  .drv_oh  (drv_oh),
  .bus_q   (bus_q),
  .regs_q  (regs_q),
  .ar_q    (ar_q),
  .dr_q    (dr_q)
);

// File: tb/bus_xfer_system_tb.sv
module bus_xfer_system_tb_top;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int NREG = 4;

  logic clk = 0;
  logic rst = 1;
  logic init_en = 0;
  logic [DW-1:0] init_data = '0;
  logic bus_en = 0;
  logic [1:0] bus_sel = '0;
  logic cond = 0;
  logic [NREG-1:0] load_en = '0;
  logic ar_ld = 0, dr_ld = 0, mem_rd = 0, mem_wr = 0;
  logic [DW-1:0] bus_q;
  logic [NREG*DW-1:0] regs_q;
  logic [AW-1:0] ar_q;
  logic [DW-1:0] dr_q;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;
  logic done = 0;

  always #5 clk = ~clk;

  bus_xfer_system dut_i (
    .clk(clk), .rst(rst), .init_en(init_en), .init_data(init_data),
    .bus_en(bus_en), .bus_sel(bus_sel), .cond(cond), .load_en(load_en),
    .ar_ld(ar_ld), .dr_ld(dr_ld), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .bus_q(bus_q), .regs_q(regs_q), .ar_q(ar_q), .dr_q(dr_q)
  );

  // reference model
  logic [DW-1:0] m_reg [NREG];
  logic [AW-1:0] m_ar;
  logic [DW-1:0] m_dr;
  logic [DW-1:0] m_mem [1 << AW];

  function automatic logic [DW-1:0] model_bus();
    if (init_en) return init_data;
    if (bus_en) return m_reg[bus_sel];
    return '0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) m_reg[i] <= '0;
      m_ar <= '0;
      m_dr <= '0;
    end else begin
      logic [DW-1:0] b;
      b = model_bus();
      for (int i = 0; i < NREG; i++) if (cond && load_en[i]) m_reg[i] <= b;
      if (cond && ar_ld) m_ar <= b[AW-1:0];
      if (mem_rd) m_dr <= m_mem[m_ar];
      else if (cond && dr_ld) m_dr <= b;
    end
    if (mem_wr) m_mem[m_ar] <= m_dr;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, sampled 3 ns after the rising edge
  always @(posedge clk) begin
    #3;
    if (!rst && !done) begin
      for (int i = 0; i < NREG; i++)
        check(regs_q[i*DW +: DW] === m_reg[i], "R3 register vs model",
              32'(regs_q[i*DW +: DW]), 32'(m_reg[i]));
      check(ar_q === m_ar, "R6 address register vs model", 32'(ar_q), 32'(m_ar));
      check(dr_q === m_dr, "R8 data register vs model", 32'(dr_q), 32'(m_dr));
      check(bus_q === model_bus(), "R2 bus vs model", 32'(bus_q), 32'(model_bus()));
    end
  end

  task automatic step(input logic ie, input logic [DW-1:0] idata, input logic be,
                      input logic [1:0] sel, input logic c, input logic [3:0] le,
                      input logic arl, input logic drl, input logic rd, input logic wr);
    @(negedge clk);
    init_en = ie; init_data = idata; bus_en = be; bus_sel = sel; cond = c;
    load_en = le; ar_ld = arl; dr_ld = drl; mem_rd = rd; mem_wr = wr;
    @(posedge clk);
    #3;
  endtask

  function automatic logic [DW-1:0] rq(input int i);
    return regs_q[i*DW +: DW];
  endfunction

  initial begin
    repeat (3) step(0, 0, 0, 0, 0, 4'b0000, 0, 0, 0, 0);
    // R1 reset state
    check(regs_q == '0 && ar_q == '0 && dr_q == '0, "R1 reset state", 32'(regs_q), 0);
    @(negedge clk); rst = 0;

    // initialise registers through the external path
    step(1, 8'h11, 0, 0, 1, 4'b0001, 0, 0, 0, 0);
    step(1, 8'h22, 0, 0, 1, 4'b0010, 0, 0, 0, 0);
    step(1, 8'h33, 0, 0, 1, 4'b0100, 0, 0, 0, 0);
    step(1, 8'h44, 0, 0, 1, 4'b1000, 0, 0, 0, 0);
    check(regs_q == 32'h44332211, "R2 external initialisation", regs_q, 32'h44332211);

    // R5: register 1 to register 2, source unchanged
    step(0, 0, 1, 2'd1, 1, 4'b0100, 0, 0, 0, 0);
    check(rq(2) == 8'h22, "R3 transfer destination", 32'(rq(2)), 32'h22);
    check(rq(1) == 8'h22, "R5 source kept", 32'(rq(1)), 32'h22);
    // self transfer
    step(0, 0, 1, 2'd3, 1, 4'b1000, 0, 0, 0, 0);
    check(rq(3) == 8'h44, "R5 self transfer", 32'(rq(3)), 32'h44);

    // R4: condition low blocks everything
    step(1, 8'h99, 0, 0, 0, 4'b1111, 1, 1, 0, 0);
    check(regs_q == 32'h44222211, "R4 cond low holds registers", regs_q, 32'h44222211);
    check(ar_q == '0 && dr_q == '0, "R4 cond low holds AR and DR", 32'({ar_q, dr_q}), 0);

    // R3: several destinations at once
    step(0, 0, 1, 2'd3, 1, 4'b0111, 0, 0, 0, 0);
    check(regs_q == 32'h44444444, "R3 multi-load", regs_q, 32'h44444444);
    step(1, 8'h5A, 0, 0, 1, 4'b0001, 0, 0, 0, 0);

    // R10: idle bus loads zero
    @(negedge clk);
    init_en = 0; bus_en = 0; cond = 0; load_en = '0; ar_ld = 0; dr_ld = 0;
    #1 check(bus_q == '0, "R10 idle bus reads zero", 32'(bus_q), 0);
    step(0, 0, 0, 2'd0, 1, 4'b1000, 0, 0, 0, 0);
    check(rq(3) == 8'h00, "R10 load from idle bus", 32'(rq(3)), 0);
    step(0, 0, 1, 2'd0, 0, 4'b0000, 0, 0, 0, 0);
    check(bus_q == 8'h5A, "R2 bus shows register 0", 32'(bus_q), 32'h5A);

    // R7: fill memory, word a = a*7+3
    for (int a = 0; a < (1 << AW); a++) begin
      step(1, 8'(a), 0, 0, 1, 4'b0000, 1, 0, 0, 0);
      step(1, 8'(a * 7 + 3), 0, 0, 1, 4'b0000, 0, 1, 0, 0);
      step(0, 0, 0, 0, 0, 4'b0000, 0, 0, 0, 1);
    end
    // R6/R8: read back word 5
    step(1, 8'd5, 0, 0, 1, 4'b0000, 1, 0, 0, 0);
    check(ar_q == 4'd5, "R6 address load", 32'(ar_q), 5);
    step(0, 0, 0, 0, 0, 4'b0000, 0, 0, 1, 0);
    check(dr_q == 8'd38, "R7 R8 memory read", 32'(dr_q), 38);
    // read priority over bus load
    step(1, 8'hFF, 0, 0, 1, 4'b0000, 1, 0, 0, 0);
    step(1, 8'h01, 0, 0, 1, 4'b0000, 0, 1, 1, 0);
    check(dr_q == 8'(15 * 7 + 3), "R8 read beats bus load", 32'(dr_q), 32'(8'(15 * 7 + 3)));

    // R9: simultaneous read and write on address 2
    step(1, 8'd2, 0, 0, 1, 4'b0000, 1, 0, 0, 0);
    step(1, 8'hAA, 0, 0, 1, 4'b0000, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 4'b0000, 0, 0, 1, 1);
    check(dr_q == 8'd17, "R9 read gets old word", 32'(dr_q), 17);
    step(0, 0, 0, 0, 0, 4'b0000, 0, 0, 1, 0);
    check(dr_q == 8'hAA, "R9 write stored old DR", 32'(dr_q), 32'hAA);

    // R1: reset in mid-run
    @(negedge clk); rst = 1;
    step(0, 0, 0, 0, 0, 4'b0000, 0, 0, 0, 0);
    check(regs_q == '0 && ar_q == '0 && dr_q == '0, "R1 mid-run reset", 32'(regs_q), 0);
    @(negedge clk); rst = 0;

    // random patterns against the model
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], 8'(r >> 8), r[2], r[4:3], r[5] | r[6], r[10:7],
           r[11] & r[12], r[13], r[14] & r[15], r[16] & r[17]);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule